// File: doc/BRIEF.md
# I2S Master Serial Transmitter

This block is the transmit half of an I2S port acting as clock master. Software-side logic writes stereo sample pairs over a simple write-only register port into a small internal FIFO. The block drives the serial bit clock, the word-select line and the serial data line. Each sample goes out MSB first, one bit clock after the word-select edge that opens its slot. The rate is set by an external strobe, `bit_tick`. Each strobe is one half period of the serial clock, so the block needs no clock divider of its own.

The slot length (bit clocks per word-select phase) and the sample resolution are set through two separate coded fields. A sample narrower than its slot is padded with trailing zeros. The serial clocks run only while both the global enable and the clock enable are set. Data flows only when the global enable, the transmit enable and the pair enable are all set. A flush strobe empties the FIFO before a stream starts.

Register map (write only, value in `wr_data`, enables use bit 0): 0 global enable, 1 transmit enable, 2 clock enable, 3 slot-length code, 4 resolution code, 5 pair enable, 6 FIFO flush, 7 left sample holding register, 8 right sample (pushes the pair).

Top module: `i2s_tx_master`

## Requirements
- R1: After reset, `sck_o`, `ws_o` and `sd_o` are 0, every enable is 0, and the FIFO is empty. The slot code resets to 16 cycles and the resolution code to 16 bits.
- R2: `sck_o` toggles on each `bit_tick` only while global enable (address 0) and clock enable (address 2) are both 1, so one serial clock period spans two strobes. Otherwise `sck_o` and `ws_o` are held low and the frame position returns to its start.
- R3: `ws_o` is low for the left slot and high for the right slot. Each slot lasts 16, 24 or 32 bit clocks for slot codes 0x00, 0x08 and 0x10 (address 3). Any other code selects 32.
- R4: `sd_o` changes only on a falling `sck_o` edge and is stable while `sck_o` is high. The MSB of a slot is sampled at the second rising edge after that slot's word-select change.
- R5: Resolution codes 0x02, 0x04 and 0x05 (address 4) select 16, 24 and 32 valid bits, and any other code selects 32. The low valid bits of a sample are sent MSB first, followed by zeros up to the slot end. When the resolution exceeds the slot, only the top slot-width bits are sent.
- R6: A write to address 7 holds a left sample. A write to address 8 pushes that left sample together with the written right sample as one FIFO entry. Entries leave in push order, one per frame, taken at the first falling edge of the frame.
- R7: If the FIFO is empty at a frame start, that whole frame is zeros.
- R8: With transmit enable (address 1) cleared, `sd_o` is 0 and no entry is taken, while the clocks keep running.
- R9: With pair enable (address 5) cleared, frames are zeros and the FIFO is left untouched.
- R10: Writing 1 to address 6 empties the FIFO.
- R11: A push into a FIFO already holding DEPTH entries is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Half-bit-period strobe that paces the serial clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select (0 left, 1 right) |
| sd_o | output | 1 | Serial data, MSB first |

## Verification
The bench goes after the one-bit delay at every word-select edge. A design that aligned the MSB with word select, or lost the last bit of the right slot, would show a shifted bit on every frame boundary. It also sweeps every slot and resolution pairing, including a resolution wider than its slot. Wrong padding or truncation there would leak low sample bits into bits that should be zero.

Further runs check that entries kept back while transmit or pair enable is off are still delivered in order later. They also check that a flush discards old entries and that pushes into a full FIFO vanish. A design that popped while disabled, or overwrote the oldest entry on overflow, would then send the wrong sample.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int SAMPLE_W = 32;
  localparam int FRAME_W  = 2 * SAMPLE_W;
  localparam int SLOT_MAX = 32;
  localparam int SLW_W    = $clog2(SLOT_MAX + 1);
  localparam int CNT_W    = $clog2(2 * SLOT_MAX);
  localparam int ADDR_W   = 4;

  localparam logic [ADDR_W-1:0] A_GEN   = 4'd0;
  localparam logic [ADDR_W-1:0] A_TXEN  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CLKEN = 4'd2;
  localparam logic [ADDR_W-1:0] A_SLOT  = 4'd3;
  localparam logic [ADDR_W-1:0] A_RES   = 4'd4;
  localparam logic [ADDR_W-1:0] A_PAIR  = 4'd5;
  localparam logic [ADDR_W-1:0] A_FLUSH = 4'd6;
  localparam logic [ADDR_W-1:0] A_LEFT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_RIGHT = 4'd8;

  function automatic logic [SLW_W-1:0] slot_of(input logic [7:0] code);
    case (code)
      8'h00:   return SLW_W'(16);
      8'h08:   return SLW_W'(24);
      default: return SLW_W'(32);
    endcase
  endfunction

  function automatic logic [SLW_W-1:0] res_of(input logic [7:0] code);
    case (code)
      8'h02:   return SLW_W'(16);
      8'h04:   return SLW_W'(24);
      default: return SLW_W'(32);
    endcase
  endfunction

  // keep the low res bits of a sample and move them to the top of the word
  function automatic logic [SAMPLE_W-1:0] shape(input logic [SAMPLE_W-1:0] s,
                                                input logic [SLW_W-1:0] res);
    int sh;
    sh = SAMPLE_W - int'(res);
    return s << sh;
  endfunction

  // serial bit at frame position idx: left word first, then right word
  function automatic logic stream_bit(input logic [FRAME_W-1:0] f,
                                      input logic [CNT_W-1:0] idx,
                                      input logic [SLW_W-1:0] slot);
    int i;
    int s;
    i = int'(idx);
    s = int'(slot);
    if (i < s) return f[FRAME_W-1-i];
    if (i - s > SAMPLE_W - 1) return 1'b0;
    return f[SAMPLE_W-1-(i-s)];
  endfunction
endpackage

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs
  import i2s_tx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [SAMPLE_W-1:0]    wr_data,
  output logic                   gen_en,
  output logic                   tx_en,
  output logic                   clk_en,
  output logic                   pair_en,
  output logic [SLW_W-1:0]       slot_w,
  output logic [SLW_W-1:0]       res_w,
  output logic                   push,
  output logic [FRAME_W-1:0]     push_data,
  output logic                   flush
);
  logic                gen_q, gen_n, tx_q, tx_n, ck_q, ck_n, pr_q, pr_n;
  logic [7:0]          slot_code_q, slot_code_n, res_code_q, res_code_n;
  logic [SAMPLE_W-1:0] hold_q, hold_n;

  always_comb begin
    gen_n       = gen_q;
    tx_n        = tx_q;
    ck_n        = ck_q;
    pr_n        = pr_q;
    slot_code_n = slot_code_q;
    res_code_n  = res_code_q;
    hold_n      = hold_q;
    push        = 1'b0;
    flush       = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        A_GEN:   gen_n       = wr_data[0];
        A_TXEN:  tx_n        = wr_data[0];
        A_CLKEN: ck_n        = wr_data[0];
        A_PAIR:  pr_n        = wr_data[0];
        A_SLOT:  slot_code_n = wr_data[7:0];
        A_RES:   res_code_n  = wr_data[7:0];
        A_FLUSH: flush       = wr_data[0];
        A_LEFT:  hold_n      = wr_data;
        A_RIGHT: push        = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q       <= 1'b0;
      tx_q        <= 1'b0;
      ck_q        <= 1'b0;
      pr_q        <= 1'b0;
      slot_code_q <= 8'h00;
      res_code_q  <= 8'h02;
      hold_q      <= '0;
    end else begin
      gen_q       <= gen_n;
      tx_q        <= tx_n;
      ck_q        <= ck_n;
      pr_q        <= pr_n;
      slot_code_q <= slot_code_n;
      res_code_q  <= res_code_n;
      hold_q      <= hold_n;
    end
  end

  assign gen_en    = gen_q;
  assign tx_en     = tx_q;
  assign clk_en    = ck_q;
  assign pair_en   = pr_q;
  assign slot_w    = slot_of(slot_code_q);
  assign res_w     = res_of(res_code_q);
  assign push_data = {hold_q, wr_data};
endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_n = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && !flush && wp_q == PTR_W'(g)) mem[g] <= din;
      end
    end
  endgenerate

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  // R11
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && $stable(wp_q)));
  // R11
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                run,
  input  logic                tx_on,
  input  logic                pair_on,
  input  logic [SLW_W-1:0]    slot_w,
  input  logic [SLW_W-1:0]    res_w,
  input  logic                fifo_empty,
  input  logic [FRAME_W-1:0]  fifo_data,
  output logic                pop,
  output logic                sck,
  output logic                ws,
  output logic                sd
);
  logic               sck_q, sck_n, ws_q, ws_n, sd_q, sd_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n, last, idx;
  logic [CNT_W:0]     last_w;
  logic [FRAME_W-1:0] frm_q, frm_n;

  assign last_w = {slot_w, 1'b0} - 1'b1;
  assign last   = last_w[CNT_W-1:0];

  always_comb begin
    sck_n = sck_q;
    ws_n  = ws_q;
    sd_n  = sd_q;
    cnt_n = cnt_q;
    frm_n = frm_q;
    idx   = '0;
    pop   = 1'b0;
    if (!run) begin
      sck_n = 1'b0;
      ws_n  = 1'b0;
      sd_n  = 1'b0;
      cnt_n = '0;
      frm_n = '0;
    end else if (bit_tick) begin
      if (!sck_q) begin
        sck_n = 1'b1;
      end else begin
        sck_n = 1'b0;
        cnt_n = (cnt_q >= last) ? '0 : cnt_q + 1'b1;
        if (cnt_q == '0) begin
          if (tx_on && pair_on && !fifo_empty) begin
            pop   = 1'b1;
            frm_n = {shape(fifo_data[FRAME_W-1:SAMPLE_W], res_w),
                     shape(fifo_data[SAMPLE_W-1:0], res_w)};
          end else begin
            frm_n = '0;
          end
        end
        ws_n = ({1'b0, cnt_n} >= (CNT_W+1)'(slot_w));
        idx  = (cnt_n == '0) ? last : cnt_n - 1'b1;
        sd_n = tx_on && stream_bit(frm_n, idx, slot_w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      ws_q  <= 1'b0;
      sd_q  <= 1'b0;
      cnt_q <= '0;
      frm_q <= '0;
    end else begin
      sck_q <= sck_n;
      ws_q  <= ws_n;
      sd_q  <= sd_n;
      cnt_q <= cnt_n;
      frm_q <= frm_n;
    end
  end

  assign sck = sck_q;
  assign ws  = ws_q;
  assign sd  = sd_q;

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sck_q && !ws_q));
  // R4
  sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(sd_q));
  // R4
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_q != $past(ws_q)) |-> !sck_q);
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
  import i2s_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic                sck_o,
  output logic                ws_o,
  output logic                sd_o
);
  logic               gen_en, tx_en, clk_en, pair_en;
  logic [SLW_W-1:0]   slot_w, res_w;
  logic               push, flush, pop, empty, full;
  logic [FRAME_W-1:0] push_data, fifo_data;

  i2s_tx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gen_en(gen_en), .tx_en(tx_en), .clk_en(clk_en),
    .pair_en(pair_en), .slot_w(slot_w), .res_w(res_w), .push(push),
    .push_data(push_data), .flush(flush)
  );

  i2s_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(FRAME_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_data), .pop(pop),
    .flush(flush), .dout(fifo_data), .empty(empty), .full(full)
  );

  i2s_tx_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .run(gen_en && clk_en), .tx_on(gen_en && tx_en), .pair_on(pair_en),
    .slot_w(slot_w), .res_w(res_w), .fifo_empty(empty),
    .fifo_data(fifo_data), .pop(pop), .sck(sck_o), .ws(ws_o), .sd(sd_o)
  );

  // R7
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R8
  no_pop_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (tx_en && gen_en && pair_en));
endmodule

// File: tb/sim_i2s_tx_master.sv
module sim_i2s_tx_master;
  localparam int DEPTH = 4;

  logic        clk, rst_n, tick, wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic        sck, ws, sd;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] q[$];
  bit b_gen, b_tx, b_pair;
  int b_slot, b_res;

  i2s_tx_master #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sck_o(sck), .ws_o(ws), .sd_o(sd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = ~tick;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  function automatic int slot_dec(input int code);
    case (code)
      'h00: return 16;
      'h08: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int res_dec(input int code);
    case (code)
      'h02: return 16;
      'h04: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] pad(input logic [31:0] s, input int res);
    logic [63:0] t;
    t = {32'd0, s} << (32 - res);
    return t[31:0];
  endfunction

  function automatic logic sbit(input logic [63:0] w, input int idx, input int slot);
    if (idx < slot) return w[63 - idx];
    return w[31 - (idx - slot)];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 4'(a);
    wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    wr(7, l);
    wr(8, r);
    if (q.size() < DEPTH) q.push_back({l, r});
  endtask

  task automatic set_cfg(input bit tx, input bit pr, input int sc, input int rc);
    b_tx = tx; b_pair = pr;
    b_slot = slot_dec(sc); b_res = res_dec(rc);
    wr(1, tx); wr(5, pr); wr(3, sc); wr(4, rc);
  endtask

  task automatic stop_clocks();
    wr(2, 0);
    repeat (6) begin
      @(negedge clk);
      check(!sck && !ws, "R2 idle", {sck, ws}, 0);
    end
  endtask

  // start clocks, then compare every rising-edge bit with the model
  task automatic run_frames(input int nf, input string tag);
    int c = 0;
    int rises = 0;
    int gap = 0;
    int wd = 0;
    int total;
    bit prev;
    logic held = 1'b0;
    logic [63:0] w = '0;
    logic [63:0] raw;
    logic exp_sd;
    int idx;
    total = nf * 2 * b_slot;
    wr(2, 1);
    prev = sck;
    while (rises < total) begin
      @(negedge clk);
      wd++; gap++;
      if (wd > 2000) begin
        check(0, "R2 sck stalled", 0, 1);
        break;
      end
      if (sck && !prev) begin
        if (rises > 0) check(gap == 4, "R2 period", gap, 4);
        gap = 0; wd = 0;
        if (c == 1) begin
          if (b_gen && b_tx && b_pair && q.size() > 0) begin
            raw = q.pop_front();
            w = {pad(raw[63:32], b_res), pad(raw[31:0], b_res)};
          end else begin
            w = '0;
          end
        end
        idx = (c == 0) ? 2 * b_slot - 1 : c - 1;
        exp_sd = (b_gen && b_tx) ? sbit(w, idx, b_slot) : 1'b0;
        check(ws == (c >= b_slot), "R3 ws", ws, (c >= b_slot));
        check(sd == exp_sd, tag, sd, exp_sd);
        held = sd;
        c = (c == 2 * b_slot - 1) ? 0 : c + 1;
        rises++;
      end else if (sck && prev) begin
        check(sd == held, "R4 sd moved while sck high", sd, held);
      end
      prev = sck;
    end
    stop_clocks();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    b_gen = 0; b_tx = 0; b_pair = 0; b_slot = 16; b_res = 16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sck && !ws && !sd, "R1 reset outputs", {sck, ws, sd}, 0);

    // R2: global enable off keeps clocks idle even with clock enable set
    wr(2, 1);
    repeat (20) begin
      @(negedge clk);
      check(!sck, "R2 gen off", sck, 0);
    end
    wr(2, 0);
    wr(0, 1); b_gen = 1;

    // R1: FIFO starts empty -> zero frame
    set_cfg(1, 1, 'h00, 'h02);
    run_frames(1, "R1 empty after reset");

    // R6: order and one-per-frame, then R7 empty frame
    push(32'h0000_A5C3, 32'h0000_81FF);
    push(32'h0000_1234, 32'h0000_FEDC);
    run_frames(3, "R6 order");
    run_frames(1, "R7 empty frame");

    // R5: 16-bit samples in 32-bit slots, and 32-bit samples in 16-bit slots
    set_cfg(1, 1, 'h10, 'h02);
    push(32'hDEAD_BEEF, 32'h1357_9BDF);
    run_frames(1, "R5 pad");
    set_cfg(1, 1, 'h00, 'h05);
    push(32'hCAFE_F00D, 32'h8000_0001);
    run_frames(1, "R5 truncate");

    // R8: transmit disabled keeps entries, then they drain
    set_cfg(0, 1, 'h08, 'h04);
    push(32'h00AB_CDEF, 32'h0080_0001);
    run_frames(2, "R8 tx off");
    check(q.size() == 1, "R8 kept", q.size(), 1);
    set_cfg(1, 1, 'h08, 'h04);
    run_frames(1, "R8 drained");

    // R9: pair disabled drives zeros and keeps the FIFO
    set_cfg(1, 0, 'h00, 'h02);
    push(32'h0000_7777, 32'h0000_1111);
    run_frames(2, "R9 pair off");
    set_cfg(1, 1, 'h00, 'h02);
    run_frames(1, "R9 pair back");

    // R10: flush discards old entries
    push(32'h0000_AAAA, 32'h0000_BBBB);
    push(32'h0000_CCCC, 32'h0000_DDDD);
    wr(6, 1);
    q.delete();
    push(32'h0000_0F0F, 32'h0000_F0F0);
    run_frames(2, "R10 flush");

    // R11: overflow drops newest
    for (int i = 0; i < DEPTH + 2; i++) push(32'h0000_1000 + i, 32'h0000_2000 + i);
    run_frames(DEPTH + 1, "R11 overflow");

    // random episodes
    for (int e = 0; e < 28; e++) begin
      int scs[4] = '{'h00, 'h08, 'h10, 'h03};
      int rcs[4] = '{'h02, 'h04, 'h05, 'h07};
      int np;
      set_cfg(($urandom % 8) != 0, ($urandom % 8) != 0,
              scs[$urandom % 4], rcs[$urandom % 4]);
      if (($urandom % 6) == 0) begin
        wr(6, 1);
        q.delete();
      end
      np = $urandom % (DEPTH + 2);
      for (int k = 0; k < np; k++) push($urandom, $urandom);
      run_frames(np + 1, "R5 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule